// File: doc/BRIEF.md
# Long-Format Three-Level Table Walker

This block turns a 32-bit input address into a 40-bit output address. It does so by reading 64-bit long-format descriptors from memory over a simple read request/response channel. A caller supplies the input address, the access kind (read or write) and the security mode (secure or non-secure). It also supplies the table base as a 32-bit low word and an 8-bit high word, which together form a 40-bit physical address. The walker then reads one descriptor per level, from level 1 down to level 3. Level 1 has 4 entries. Levels 2 and 3 have 512 entries each.

A walk ends in one of two ways. It either returns the translated address with the leaf's attributes, or it returns a fault with a code and the level at which the fault occurred. Leaves may be 4 KiB pages at level 3 or 2 MiB blocks at level 2. The walker goes beyond the usual inheritance rule on security: for a non-secure request, every table descriptor and the leaf must each carry their own non-secure marker.

Only one walk is in flight at a time. A new request is taken only once the previous result has been delivered.

Top module: `tbl_walker`

## Requirements
- R1: Descriptor read addresses are formed as follows:
  - Level 1: `{base[39:5], va[31:30], 3'b000}`, where `base = {baseHi, baseLo}`.
  - Level 2: `{T[39:12], va[29:21], 3'b000}`.
  - Level 3: `{T[39:12], va[20:12], 3'b000}`.
  - Here T is bits 39:12 of the table descriptor read at the level above.
- R2: Descriptor bits 1:0 are decoded as follows. The value 3 is a table pointer at levels 1 and 2 and a page at level 3. A page returns `resAddr = {d[39:12], va[11:0]}` with `resLevel = 3`.
- R3: At level 2, bits 1:0 equal to 1 mark a 2 MiB block. The walk ends after two reads with `resAddr = {d[39:21], va[20:0]}` and `resLevel = 2`.
- R4: A translation fault (`resFaultCode = 1`) is reported at the level of the descriptor in these cases:
  - bit 0 of the descriptor is clear;
  - bits 1:0 equal 1 at level 1 or at level 3.
- R5: For a non-secure request, a secure access fault (`resFaultCode = 5`) is reported at the offending level in these cases:
  - a table descriptor has bit 63 clear;
  - the leaf has bit 5 clear.
  
  A secure request ignores both bits.
- R6: A leaf with bit 7 set is read-only. A write to it gives a permission fault (`resFaultCode = 4`, at the leaf level). A read of it succeeds with `resReadOnly = 1`. The secure access check (R5) takes precedence over the permission check.
- R7: An error response to a descriptor read ends the walk with an abort (`resFaultCode = 7`) at the level being read.
- R8: A successful result reports the leaf fields as follows:
  - `resAttrIdx = d[3:2]`
  - `resXn = d[54:53]`
  - `resContig = d[52]`
  - `resReadOnly = d[7]`
  
  On success, `resFault = 0` and `resFaultCode = 0`.
- R9: The walker runs one walk at a time:
  - `reqReady` is high only when the walker is idle, and a request offered while busy is ignored.
  - `resValid` is a one-cycle pulse.
  - `reqReady` returns in the cycle after the pulse.
- R10: While `memReqValid` is high and `memReqReady` is low, `memReqValid` and `memReqAddr` hold steady.
- R11: After reset, `reqReady = 1`, `memReqValid = 0` and `resValid = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle, request accepted on this cycle |
| reqAddr | input | 32 | Input address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqNonSec | input | 1 | 1 = non-secure request |
| baseLo | input | 32 | Table base bits 31:0 |
| baseHi | input | 8 | Table base bits 39:32 |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 40 | Descriptor byte address |
| memRspValid | input | 1 | Descriptor read data valid |
| memRspData | input | 64 | Descriptor value |
| memRspErr | input | 1 | Read returned an error |
| resValid | output | 1 | Result pulse |
| resFault | output | 1 | Walk ended with a fault |
| resFaultCode | output | 3 | 0 none, 1 translation, 4 permission, 5 secure access, 7 abort |
| resLevel | output | 2 | Level of the leaf or of the fault (1..3) |
| resAddr | output | 40 | Output address (0 on fault) |
| resAttrIdx | output | 2 | Memory attribute index of the leaf |
| resXn | output | 2 | Execute-never bits of the leaf |
| resReadOnly | output | 1 | Leaf is read-only |
| resContig | output | 1 | Leaf carries the contiguous hint |

## Verification
A wrong level counter or table register shows up as a wrong `memReqAddr` on the very next descriptor read. It also shows up as the wrong number of reads before `resValid`, so the bench logs every read address and compares the whole sequence. A decode or precedence error surfaces only in the single result pulse. It appears as a wrong code, level or address, one cycle after the last response. Each fault class therefore gets its own stimulus, and some stimuli carry two faults at once to expose the order of the checks. A stuck control state appears as a missing result or as a `reqReady` that does not return the cycle after the pulse.

// File: rtl/tbl_walker_pkg.sv
package tbl_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walkState_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_XLAT  = 3'd1,
    FLT_PERM  = 3'd4,
    FLT_SEC   = 3'd5,
    FLT_ABORT = 3'd7
  } fltCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new request
    logic step;    // descend one level using the current table descriptor
    logic finish;  // latch the final result from the current response
  } walkStrb_t;

endpackage

// File: rtl/tbl_walker_ctrl.sv
module tbl_walker_ctrl
  import tbl_walker_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      descTable,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      resValid,
  output walkStrb_t strb
);

  walkState_e stateR, stateNx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateR <= ST_IDLE;
    else        stateR <= stateNx;
  end

  always_comb begin
    stateNx     = stateR;
    strb        = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    resValid    = 1'b0;
    unique case (stateR)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.load = 1'b1;
          stateNx   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNx = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (descTable) begin
            strb.step = 1'b1;
            stateNx   = ST_ISSUE;
          end else begin
            strb.finish = 1'b1;
            stateNx     = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        resValid = 1'b1;
        stateNx  = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tbl_walker_dp.sv
module tbl_walker_dp
  import tbl_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrb_t         strb,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic [PA_W-1:0]   reqBase,
  input  logic [DESC_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              descTable,
  output logic              resFault,
  output logic [2:0]        resFaultCode,
  output logic [1:0]        resLevel,
  output logic [PA_W-1:0]   resAddr,
  output logic [1:0]        resAttrIdx,
  output logic [1:0]        resXn,
  output logic              resReadOnly,
  output logic              resContig
);

  localparam int DSZ      = 3;                    // log2 of descriptor bytes
  localparam int L2_SHIFT = PAGE_SHIFT + IDX_W;   // block size shift
  localparam int L1_SHIFT = L2_SHIFT + IDX_W;
  localparam int L1_W     = VA_W - L1_SHIFT;
  localparam int L1_ALIGN = L1_W + DSZ;

  // descriptor bit positions
  localparam int B_NSTBL  = 63;
  localparam int B_XN     = 53;
  localparam int B_CONT   = 52;
  localparam int B_RO     = 7;
  localparam int B_NSLEAF = 5;
  localparam int B_ATTR   = 2;

  logic [VA_W-1:0] vaR;
  logic            wrR, nsR;
  logic [PA_W-1:0] tblR;
  logic [1:0]      lvlR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaR  <= '0;
      wrR  <= 1'b0;
      nsR  <= 1'b0;
      tblR <= '0;
      lvlR <= 2'd1;
    end else if (strb.load) begin
      vaR  <= reqAddr;
      wrR  <= reqWrite;
      nsR  <= reqNonSec;
      tblR <= reqBase;
      lvlR <= 2'd1;
    end else if (strb.step) begin
      tblR <= {memRspData[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      lvlR <= lvlR + 2'd1;
    end
  end

  // descriptor address for the current level
  always_comb begin
    unique case (lvlR)
      2'd1:    memReqAddr = {tblR[PA_W-1:L1_ALIGN], vaR[VA_W-1:L1_SHIFT], {DSZ{1'b0}}};
      2'd2:    memReqAddr = {tblR[PA_W-1:PAGE_SHIFT], vaR[L1_SHIFT-1:L2_SHIFT], {DSZ{1'b0}}};
      default: memReqAddr = {tblR[PA_W-1:PAGE_SHIFT], vaR[L2_SHIFT-1:PAGE_SHIFT], {DSZ{1'b0}}};
    endcase
  end

  // descriptor decode and fault priority
  logic     isTbl, isLeaf;
  fltCode_e code;

  always_comb begin
    isTbl  = (memRspData[1:0] == 2'b11) && (lvlR != 2'd3);
    isLeaf = ((memRspData[1:0] == 2'b11) && (lvlR == 2'd3)) ||
             ((memRspData[1:0] == 2'b01) && (lvlR == 2'd2));
    code = FLT_NONE;
    if (memRspErr)                                 code = FLT_ABORT;
    else if (!isTbl && !isLeaf)                    code = FLT_XLAT;
    else if (nsR && isTbl && !memRspData[B_NSTBL]) code = FLT_SEC;
    else if (nsR && isLeaf && !memRspData[B_NSLEAF]) code = FLT_SEC;
    else if (isLeaf && wrR && memRspData[B_RO])    code = FLT_PERM;
    descTable = isTbl && (code == FLT_NONE);
  end

  logic [PA_W-1:0] leafAddr;
  assign leafAddr = (lvlR == 2'd2)
                  ? {memRspData[PA_W-1:L2_SHIFT], vaR[L2_SHIFT-1:0]}
                  : {memRspData[PA_W-1:PAGE_SHIFT], vaR[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resFault     <= 1'b0;
      resFaultCode <= '0;
      resLevel     <= '0;
      resAddr      <= '0;
      resAttrIdx   <= '0;
      resXn        <= '0;
      resReadOnly  <= 1'b0;
      resContig    <= 1'b0;
    end else if (strb.finish) begin
      resFault     <= (code != FLT_NONE);
      resFaultCode <= code;
      resLevel     <= lvlR;
      if (code == FLT_NONE) begin
        resAddr     <= leafAddr;
        resAttrIdx  <= memRspData[B_ATTR+1:B_ATTR];
        resXn       <= memRspData[B_XN+1:B_XN];
        resReadOnly <= memRspData[B_RO];
        resContig   <= memRspData[B_CONT];
      end else begin
        resAddr     <= '0;
        resAttrIdx  <= '0;
        resXn       <= '0;
        resReadOnly <= 1'b0;
        resContig   <= 1'b0;
      end
    end
  end

  logic unusedDesc;
  assign unusedDesc = ^{memRspData[B_NSTBL-1:B_XN+2], memRspData[B_CONT-1:PA_W],
                        memRspData[PAGE_SHIFT-1:B_RO+1], memRspData[B_RO-1],
                        memRspData[B_NSLEAF-1]};

endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import tbl_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 40,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic [31:0]       baseLo,
  input  logic [PA_W-33:0]  baseHi,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              resValid,
  output logic              resFault,
  output logic [2:0]        resFaultCode,
  output logic [1:0]        resLevel,
  output logic [PA_W-1:0]   resAddr,
  output logic [1:0]        resAttrIdx,
  output logic [1:0]        resXn,
  output logic              resReadOnly,
  output logic              resContig
);

  walkStrb_t strb;
  logic      descTable;

  tbl_walker_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .descTable  (descTable),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .resValid   (resValid),
    .strb       (strb)
  );

  tbl_walker_dp #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .DESC_W    (DESC_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W     (IDX_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqNonSec   (reqNonSec),
    .reqBase     ({baseHi, baseLo}),
    .memRspData  (memRspData),
    .memRspErr   (memRspErr),
    .memReqAddr  (memReqAddr),
    .descTable   (descTable),
    .resFault    (resFault),
    .resFaultCode(resFaultCode),
    .resLevel    (resLevel),
    .resAddr     (resAddr),
    .resAttrIdx  (resAttrIdx),
    .resXn       (resXn),
    .resReadOnly (resReadOnly),
    .resContig   (resContig)
  );

endmodule

// File: rtl/tbl_walker_chk.sv
module tbl_walker_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 40,
  parameter int DESC_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic [VA_W-1:0]   reqAddr,
  input logic              reqWrite,
  input logic              reqNonSec,
  input logic [31:0]       baseLo,
  input logic [PA_W-33:0]  baseHi,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [PA_W-1:0]   memReqAddr,
  input logic              memRspValid,
  input logic [DESC_W-1:0] memRspData,
  input logic              memRspErr,
  input logic              resValid,
  input logic              resFault,
  input logic [2:0]        resFaultCode,
  input logic [1:0]        resLevel,
  input logic [PA_W-1:0]   resAddr,
  input logic [1:0]        resAttrIdx,
  input logic [1:0]        resXn,
  input logic              resReadOnly,
  input logic              resContig
);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid && reqReady);

  // R9
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  // R9
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memReqValid && !resValid);

  // R4
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resFault |-> (resFaultCode == 3'd1 || resFaultCode == 3'd4 ||
                              resFaultCode == 3'd5 || resFaultCode == 3'd7) &&
                             resLevel != 2'd0);

  // R8
  ok_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !resFault |-> resFaultCode == 3'd0 &&
                              (resLevel == 2'd2 || resLevel == 2'd3));

endmodule

bind tbl_walker tbl_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W)) chk_i (.*);

// File: tb/tbl_walker_tb.sv
module tbl_walker_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqNonSec = 1'b0;
  logic [31:0] baseLo = '0;
  logic [7:0]  baseHi = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [39:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        resValid, resFault, resReadOnly, resContig;
  logic [2:0]  resFaultCode;
  logic [1:0]  resLevel, resAttrIdx, resXn;
  logic [39:0] resAddr;

  tbl_walker dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model: accepts reads, answers two edges later
  logic [63:0] memArr [logic [39:0]];
  logic [39:0] addrLog [$];
  logic        errEn = 1'b0;
  logic [39:0] errAddr = '0;
  logic        pendR = 1'b0;
  logic [39:0] pendAddr = '0;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    memRspErr   <= 1'b0;
    if (pendR) begin
      pendR       <= 1'b0;
      memRspValid <= 1'b1;
      memRspData  <= memArr.exists(pendAddr) ? memArr[pendAddr] : 64'h0;
      memRspErr   <= errEn && (pendAddr == errAddr);
    end
    if (memReqValid && memReqReady && rst_n) begin
      pendR    <= 1'b1;
      pendAddr <= memReqAddr;
      addrLog.push_back(memReqAddr);
    end
  end

  // result capture
  logic        rFault, rRo, rCont;
  logic [2:0]  rCode;
  logic [1:0]  rLvl, rAttr, rXn;
  logic [39:0] rPa;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] l1a(input logic [39:0] b, input logic [31:0] va);
    return {b[39:5], va[31:30], 3'b000};
  endfunction
  function automatic logic [39:0] l2a(input logic [39:0] t, input logic [31:0] va);
    return {t[39:12], va[29:21], 3'b000};
  endfunction
  function automatic logic [39:0] l3a(input logic [39:0] t, input logic [31:0] va);
    return {t[39:12], va[20:12], 3'b000};
  endfunction
  function automatic logic [63:0] mkTbl(input logic [39:0] a, input logic nsT);
    return {nsT, 23'b0, a[39:12], 10'b0, 2'b11};
  endfunction
  function automatic logic [63:0] mkLeaf(input logic [39:0] a, input logic [1:0] typ,
                                         input logic ns5, input logic ro,
                                         input logic [1:0] attr, input logic [1:0] xn,
                                         input logic cont);
    logic [63:0] d;
    d = '0;
    d[39:12] = a[39:12];
    d[1:0]   = typ;
    d[5]     = ns5;
    d[6]     = 1'b1;
    d[7]     = ro;
    d[3:2]   = attr;
    d[54:53] = xn;
    d[52]    = cont;
    return d;
  endfunction

  localparam logic [39:0] BASE = 40'h01_0000_0040;
  localparam logic [39:0] T1   = 40'h02_0000_1000;
  localparam logic [39:0] T2   = 40'h03_0000_2000;
  localparam logic [39:0] PG   = 40'h45_6789_A000;
  localparam logic [39:0] BLK  = 40'h7A_BCC0_0000;

  // three-level page mapping for va
  task automatic buildPage(input logic [31:0] va, input logic ns1, input logic ns2,
                           input logic ns5, input logic ro, input logic [63:0] l3Override,
                           input logic useOverride);
    memArr.delete();
    memArr[l1a(BASE, va)] = mkTbl(T1, ns1);
    memArr[l2a(T1, va)]   = mkTbl(T2, ns2);
    memArr[l3a(T2, va)]   = useOverride ? l3Override
                          : mkLeaf(PG, 2'b11, ns5, ro, 2'b01, 2'b10, 1'b0);
  endtask

  task automatic waitResult();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (resValid) begin
        rFault = resFault; rCode = resFaultCode; rLvl = resLevel; rPa = resAddr;
        rAttr = resAttrIdx; rXn = resXn; rRo = resReadOnly; rCont = resContig;
        return;
      end
    end
    chk("R9", "result timeout", 0, 1);
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic ns);
    @(negedge clk);
    addrLog.delete();
    reqAddr = va; reqWrite = wr; reqNonSec = ns;
    baseLo = BASE[31:0]; baseHi = BASE[39:32];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitResult();
  endtask

  task automatic tReset();
    chk("R11", "reqReady after reset", reqReady, 1);
    chk("R11", "memReqValid after reset", memReqValid, 0);
    chk("R11", "resValid after reset", resValid, 0);
  endtask

  task automatic tPage();
    logic [31:0] va = 32'h8765_4321;
    buildPage(va, 1, 1, 1, 0, '0, 0);
    walk(va, 0, 1);
    chk("R2", "page fault flag", rFault, 0);
    chk("R2", "page addr", rPa, {PG[39:12], va[11:0]});
    chk("R2", "page level", rLvl, 3);
    chk("R1", "read count", addrLog.size(), 3);
    if (addrLog.size() == 3) begin
      chk("R1", "L1 addr", addrLog[0], l1a(BASE, va));
      chk("R1", "L2 addr", addrLog[1], l2a(T1, va));
      chk("R1", "L3 addr", addrLog[2], l3a(T2, va));
    end
    chk("R8", "attr idx", rAttr, 2'b01);
    chk("R8", "xn", rXn, 2'b10);
    chk("R8", "contig", rCont, 0);
    chk("R8", "code on success", rCode, 0);
  endtask

  task automatic tBlock();
    logic [31:0] va = 32'h4123_4567;
    memArr.delete();
    memArr[l1a(BASE, va)] = mkTbl(T1, 1);
    memArr[l2a(T1, va)]   = mkLeaf(BLK, 2'b01, 1, 1, 2'b11, 2'b01, 1);
    walk(va, 0, 0);
    chk("R3", "block fault flag", rFault, 0);
    chk("R3", "block addr", rPa, {BLK[39:21], va[20:0]});
    chk("R3", "block level", rLvl, 2);
    chk("R3", "block read count", addrLog.size(), 2);
    chk("R8", "block contig", rCont, 1);
    chk("R8", "block xn", rXn, 2'b01);
    chk("R6", "read of read-only ok", rRo, 1);
  endtask

  task automatic tXlat();
    logic [31:0] va = 32'hC000_5000;
    memArr.delete();
    walk(va, 0, 0);
    chk("R4", "empty L1 code", rCode, 1);
    chk("R4", "empty L1 level", rLvl, 1);
    chk("R4", "empty L1 reads", addrLog.size(), 1);
    memArr[l1a(BASE, va)] = mkLeaf(BLK, 2'b01, 1, 0, 0, 0, 0);
    walk(va, 0, 0);
    chk("R4", "L1 block type code", rCode, 1);
    chk("R4", "L1 block type level", rLvl, 1);
    buildPage(va, 1, 1, 1, 0, 64'h0000_0045_6789_A002, 1);
    walk(va, 0, 0);
    chk("R4", "L3 bit0 clear code", rCode, 1);
    chk("R4", "L3 bit0 clear level", rLvl, 3);
    chk("R4", "L3 fault addr zero", rPa, 0);
  endtask

  task automatic tSecure();
    logic [31:0] va = 32'h0ABC_DEF0;
    buildPage(va, 0, 1, 1, 0, '0, 0);
    walk(va, 0, 1);
    chk("R5", "L1 table NS clear code", rCode, 5);
    chk("R5", "L1 table NS clear level", rLvl, 1);
    walk(va, 0, 0);
    chk("R5", "secure ignores table bit", rFault, 0);
    buildPage(va, 1, 0, 1, 0, '0, 0);
    walk(va, 1, 1);
    chk("R5", "L2 table NS clear level", rLvl, 2);
    chk("R5", "L2 table NS clear code", rCode, 5);
    buildPage(va, 1, 1, 0, 0, '0, 0);
    walk(va, 0, 1);
    chk("R5", "leaf NS clear code", rCode, 5);
    chk("R5", "leaf NS clear level", rLvl, 3);
    walk(va, 0, 0);
    chk("R5", "secure ignores leaf bit", rPa, {PG[39:12], va[11:0]});
  endtask

  task automatic tPerm();
    logic [31:0] va = 32'h5555_1234;
    buildPage(va, 1, 1, 1, 1, '0, 0);
    walk(va, 1, 1);
    chk("R6", "write to read-only code", rCode, 4);
    chk("R6", "write to read-only level", rLvl, 3);
    walk(va, 0, 1);
    chk("R6", "read of read-only flag", rRo, 1);
    chk("R6", "read of read-only fault", rFault, 0);
    buildPage(va, 1, 1, 0, 1, '0, 0);
    walk(va, 1, 1);
    chk("R6", "secure before permission", rCode, 5);
  endtask

  task automatic tAbort();
    logic [31:0] va = 32'h9000_0ABC;
    buildPage(va, 1, 1, 1, 0, '0, 0);
    errEn = 1'b1; errAddr = l2a(T1, va);
    walk(va, 0, 1);
    errEn = 1'b0;
    chk("R7", "abort code", rCode, 7);
    chk("R7", "abort level", rLvl, 2);
    chk("R7", "abort read count", addrLog.size(), 2);
  endtask

  task automatic tBusy();
    logic [31:0] va  = 32'h8765_4321;
    logic [31:0] va2 = 32'h1111_2222;
    buildPage(va, 1, 1, 1, 0, '0, 0);
    @(negedge clk);
    addrLog.delete();
    reqAddr = va; reqWrite = 0; reqNonSec = 1; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = va2;
    chk("R9", "reqReady while busy", reqReady, 0);
    waitResult();
    chk("R9", "reqReady during result", reqReady, 0);
    reqValid = 1'b0;
    chk("R9", "busy request ignored", rPa, {PG[39:12], va[11:0]});
    @(negedge clk);
    chk("R9", "reqReady after result", reqReady, 1);
    chk("R9", "result is one pulse", resValid, 0);
    chk("R9", "no extra reads", addrLog.size(), 3);
  endtask

  task automatic tStall();
    logic [31:0] va = 32'h3210_FEDC;
    logic [39:0] held;
    buildPage(va, 1, 1, 1, 0, '0, 0);
    @(negedge clk);
    addrLog.delete();
    memReqReady = 1'b0;
    reqAddr = va; reqWrite = 0; reqNonSec = 0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    held = memReqAddr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "valid held", memReqValid, 1);
      chk("R10", "addr held", memReqAddr, held);
    end
    memReqReady = 1'b1;
    waitResult();
    chk("R10", "addr after stall", rPa, {PG[39:12], va[11:0]});
    chk("R10", "stalled first addr", held, l1a(BASE, va));
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog act=%0d exp=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tPage();
    tBlock();
    tXlat();
    tSecure();
    tPerm();
    tAbort();
    tBusy();
    tStall();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule